// File: doc/BRIEF.md
# Register Window Decoder

This block sits on a simple synchronous register bus and sorts every access by the low twelve bits of its address. Two windows, a core window and a FIFO window, are passed through to a downstream USB-core port. The core window keeps the low nine address bits. The FIFO window is folded onto a short row of per-endpoint FIFO offsets. Both windows accept byte, halfword and word accesses. The read data that comes back from the core is returned to the requester unchanged.

Word accesses above the forwarding windows reach a local system-register file. The file holds a device configuration word, a scratch word, a test-reset word, an endpoint-zero configuration and two banks of per-endpoint transfer-size words. One bank is for transmit endpoints and one is for receive endpoints. Every write to an endpoint-size location also raises a one-cycle size-update strobe towards the core. The strobe carries the endpoint number, the transfer length and a direction flag.

An access to an offset that decodes to nothing reads as zero and changes no state. It also raises a one-cycle unmapped flag. Every access is answered exactly one cycle after it is presented.

Top module: `regwin_decoder`

## Requirements
- R1: Only address bits 11:0 are decoded; an access whose upper address bits differ behaves exactly as the same access at its low-12-bit offset.
- R2: An access at offset 0x400–0x5FF of any size (req_size 0 = byte, 1 = halfword, 2 = word) appears on the core port one cycle later with core_addr = offset[8:0] and the same write flag, size and write data; rsp_valid rises in that same cycle and rsp_rdata equals core_rdata.
- R3: An access at offset 0x600–0x7FF of any size is forwarded like R2 but with core_addr = 0x20 + ((offset >> 3) AND 0x3C).
- R4: Offsets 0x800 and above are reachable only with req_size = 2; a byte or halfword access there is treated as unmapped (R12) and changes no register.
- R5: The device configuration word at 0x800 reads back what was written, and host_mode shows its bit 16 from the cycle after the write.
- R6: A write to 0x800 with bit 15 set leaves the configuration word unchanged and pulses illegal_wr for one cycle.
- R7: A write to 0x908 stores data bits 8:0 (reads return them zero-extended) and pulses sz_valid with sz_ep = 0, sz_len = data bits 6:0 and sz_tx = data bit 7.
- R8: Offsets 0x90C + 4*i for i = 0..14 hold transmit-size words that read back in full; a write pulses sz_valid with sz_ep = i+1, sz_len = data bits 30:0 and sz_tx = 1.
- R9: Offsets 0x94C + 4*i for i = 0..14 hold receive-size words handled as in R8 but with sz_tx = 0, and writes to one bank leave the other bank unchanged.
- R10: The test-reset word at 0x9D8 reads 0x0000A596 after reset and is writable; the scratch word at 0x9C4 is read/write.
- R11: Offsets 0x988–0x9C3 and 0x9C8 read as zero, keep no state on a write and raise neither the unmapped flag nor a strobe.
- R12: Any other offset reads zero, ignores writes and pulses unmapped for one cycle; nothing is forwarded to the core for it.
- R13: After reset all response, core, strobe and flag outputs are low, host_mode is low, and every stored word except the test-reset word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Byte address; only bits 11:0 decoded |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_rdata | output | DATA_W | Read data (zero for unmapped and zero-read offsets) |
| core_valid | output | 1 | Forwarded access to the USB core |
| core_write | output | 1 | Forwarded write flag |
| core_size | output | 2 | Forwarded access size |
| core_addr | output | CORE_AW | Remapped core offset |
| core_wdata | output | DATA_W | Forwarded write data |
| core_rdata | input | DATA_W | Core read data, valid while core_valid is high |
| sz_valid | output | 1 | Endpoint size-update strobe |
| sz_ep | output | 4 | Endpoint number of the update |
| sz_len | output | DATA_W-1 | Transfer length of the update |
| sz_tx | output | 1 | 1 = transmit direction, 0 = receive |
| host_mode | output | 1 | Host-mode select from the configuration word |
| illegal_wr | output | 1 | One-cycle pulse for a rejected configuration write |
| unmapped | output | 1 | One-cycle pulse for an access to an unmapped offset |

## Verification
A wrong decode shows in the very next cycle: a forwarded access goes out with the wrong core offset, a strobe fires for the wrong endpoint or direction, or the unmapped flag rises where a register should have answered. A stored word that was corrupted, written into the wrong bank or reset to the wrong value only shows when that location is read back. For that reason every written location is read again later, after writes to neighbouring and aliasing offsets, and the result is compared with a behavioural model of the whole map. The model is checked on every clock, so a wrong one-cycle flag or strobe is caught in the cycle where it appears.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_CORE,
    RG_FIFO,
    RG_DEVCFG,
    RG_EP0,
    RG_EPIN,
    RG_EPOUT,
    RG_ZERO,
    RG_SCRATCH,
    RG_TRST
  } region_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam int OFF_W = 12;

  localparam logic [OFF_W-1:0] CORE_LO  = 12'h400;
  localparam logic [OFF_W-1:0] FIFO_LO  = 12'h600;
  localparam logic [OFF_W-1:0] SYS_LO   = 12'h800;
  localparam logic [OFF_W-1:0] DEVCFG   = 12'h800;
  localparam logic [OFF_W-1:0] EP0CFG   = 12'h908;
  localparam logic [OFF_W-1:0] EPIN_LO  = 12'h90C;
  localparam logic [OFF_W-1:0] EPOUT_LO = 12'h94C;
  localparam logic [OFF_W-1:0] MPS_LO   = 12'h988;
  localparam logic [OFF_W-1:0] SCRATCH  = 12'h9C4;
  localparam logic [OFF_W-1:0] WAITCNT  = 12'h9C8;
  localparam logic [OFF_W-1:0] TRSTREG  = 12'h9D8;

  localparam logic [OFF_W-1:0] FIFO_SEL_MASK  = 12'h03C;
  localparam logic [8:0]       FIFO_CORE_BASE = 9'h020;

endpackage

// File: rtl/regwin_addr_dec.sv
module regwin_addr_dec
  import regwin_pkg::*;
#(
  parameter int EP_COUNT = 15,
  parameter int IDX_W    = 4,
  parameter int CORE_AW  = 9
) (
  input  logic [OFF_W-1:0]   off,
  input  logic [1:0]         size,
  output region_e            region,
  output logic [IDX_W-1:0]   ep_idx,
  output logic [CORE_AW-1:0] core_addr
);

  localparam logic [OFF_W-1:0] BANK_BYTES = OFF_W'(EP_COUNT * 4);

  logic [OFF_W-1:0] in_rel, out_rel, mps_rel;

  assign in_rel  = off - EPIN_LO;
  assign out_rel = off - EPOUT_LO;
  assign mps_rel = off - MPS_LO;

  always_comb begin
    region    = RG_NONE;
    ep_idx    = '0;
    core_addr = '0;
    if (off >= CORE_LO && off < FIFO_LO) begin
      region    = RG_CORE;
      core_addr = off[CORE_AW-1:0];
    end else if (off >= FIFO_LO && off < SYS_LO) begin
      region    = RG_FIFO;
      core_addr = CORE_AW'(FIFO_CORE_BASE) + CORE_AW'((off >> 3) & FIFO_SEL_MASK);
    end else if (off >= SYS_LO && size == SZ_WORD) begin
      if (off == DEVCFG) begin
        region = RG_DEVCFG;
      end else if (off == EP0CFG) begin
        region = RG_EP0;
      end else if (off >= EPIN_LO && in_rel < BANK_BYTES) begin
        region = RG_EPIN;
        ep_idx = IDX_W'(in_rel >> 2);
      end else if (off >= EPOUT_LO && out_rel < BANK_BYTES) begin
        region = RG_EPOUT;
        ep_idx = IDX_W'(out_rel >> 2);
      end else if ((off >= MPS_LO && mps_rel < BANK_BYTES) || off == WAITCNT) begin
        region = RG_ZERO;
      end else if (off == SCRATCH) begin
        region = RG_SCRATCH;
      end else if (off == TRSTREG) begin
        region = RG_TRST;
      end
    end
  end

endmodule

// File: rtl/regwin_ep_bank.sv
module regwin_ep_bank #(
  parameter int DEPTH  = 15,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (wr_en && idx < IDX_W'(DEPTH)) mem[idx] <= wdata;
      rdata <= (idx < IDX_W'(DEPTH)) ? mem[idx] : '0;
    end
  end

  // R8
  bank_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> idx < IDX_W'(DEPTH));

endmodule

// File: rtl/regwin_sysregs.sv
module regwin_sysregs
  import regwin_pkg::*;
#(
  parameter int               DATA_W    = 32,
  parameter int               EP0_W     = 9,
  parameter int               HOST_BIT  = 16,
  parameter int               PTEST_BIT = 15,
  parameter logic [DATA_W-1:0] TRST_INIT = 32'h0000_A596
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic              wr,
  input  region_e           region,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              host_mode,
  output logic              illegal_wr
);

  logic [DATA_W-1:0] cfg_q, scratch_q, trst_q;
  logic [EP0_W-1:0]  ep0_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= '0;
      scratch_q  <= '0;
      trst_q     <= TRST_INIT;
      ep0_q      <= '0;
      rdata      <= '0;
      illegal_wr <= 1'b0;
    end else begin
      illegal_wr <= 1'b0;
      if (acc && wr) begin
        case (region)
          RG_DEVCFG: begin
            if (wdata[PTEST_BIT]) illegal_wr <= 1'b1;
            else                  cfg_q      <= wdata;
          end
          RG_EP0:     ep0_q     <= wdata[EP0_W-1:0];
          RG_SCRATCH: scratch_q <= wdata;
          RG_TRST:    trst_q    <= wdata;
          default: ;
        endcase
      end
      case (region)
        RG_DEVCFG:  rdata <= cfg_q;
        RG_EP0:     rdata <= DATA_W'(ep0_q);
        RG_SCRATCH: rdata <= scratch_q;
        RG_TRST:    rdata <= trst_q;
        default:    rdata <= '0;
      endcase
    end
  end

  assign host_mode = cfg_q[HOST_BIT];

  // R6
  cfg_reject_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_wr |-> $stable(cfg_q));

  // R10
  trst_init_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> trst_q == TRST_INIT);

endmodule

// File: rtl/regwin_decoder.sv
module regwin_decoder
  import regwin_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int EP_COUNT = 15,
  parameter int CORE_AW  = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [1:0]          req_size,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                core_valid,
  output logic                core_write,
  output logic [1:0]          core_size,
  output logic [CORE_AW-1:0]  core_addr,
  output logic [DATA_W-1:0]   core_wdata,
  input  logic [DATA_W-1:0]   core_rdata,
  output logic                sz_valid,
  output logic [3:0]          sz_ep,
  output logic [DATA_W-2:0]   sz_len,
  output logic                sz_tx,
  output logic                host_mode,
  output logic                illegal_wr,
  output logic                unmapped
);

  localparam int IDX_W     = 4;
  localparam int LEN_W     = DATA_W - 1;
  localparam int EP0_LEN_W = 7;
  localparam int EP0_DIR   = 7;
  localparam int NBANK     = 2;

  region_e              region, region_q;
  logic [IDX_W-1:0]     ep_idx;
  logic [CORE_AW-1:0]   fwd_addr;
  logic                 is_fwd, is_size;
  logic [DATA_W-1:0]    sys_rd;
  logic [DATA_W-1:0]    bank_rd [NBANK];
  logic                 unused_addr_hi;

  assign unused_addr_hi = ^req_addr[ADDR_W-1:OFF_W];

  regwin_addr_dec #(
    .EP_COUNT (EP_COUNT),
    .IDX_W    (IDX_W),
    .CORE_AW  (CORE_AW)
  ) u_dec (
    .off       (req_addr[OFF_W-1:0]),
    .size      (req_size),
    .region    (region),
    .ep_idx    (ep_idx),
    .core_addr (fwd_addr)
  );

  assign is_fwd  = (region == RG_CORE) || (region == RG_FIFO);
  assign is_size = (region == RG_EP0) || (region == RG_EPIN) || (region == RG_EPOUT);

  regwin_sysregs #(
    .DATA_W (DATA_W)
  ) u_sys (
    .clk        (clk),
    .rst        (rst),
    .acc        (req_valid),
    .wr         (req_write),
    .region     (region),
    .wdata      (req_wdata),
    .rdata      (sys_rd),
    .host_mode  (host_mode),
    .illegal_wr (illegal_wr)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    localparam region_e BANK_RG = (g == 0) ? RG_EPIN : RG_EPOUT;
    regwin_ep_bank #(
      .DEPTH  (EP_COUNT),
      .IDX_W  (IDX_W),
      .DATA_W (DATA_W)
    ) u_bank (
      .clk   (clk),
      .rst   (rst),
      .wr_en (req_valid && req_write && region == BANK_RG),
      .idx   (ep_idx),
      .wdata (req_wdata),
      .rdata (bank_rd[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      region_q   <= RG_NONE;
      core_valid <= 1'b0;
      core_write <= 1'b0;
      core_size  <= '0;
      core_addr  <= '0;
      core_wdata <= '0;
      sz_valid   <= 1'b0;
      sz_ep      <= '0;
      sz_len     <= '0;
      sz_tx      <= 1'b0;
      unmapped   <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      region_q   <= req_valid ? region : RG_NONE;
      core_valid <= req_valid && is_fwd;
      unmapped   <= req_valid && region == RG_NONE;
      sz_valid   <= req_valid && req_write && is_size;
      if (req_valid && is_fwd) begin
        core_write <= req_write;
        core_size  <= req_size;
        core_addr  <= fwd_addr;
        core_wdata <= req_wdata;
      end
      if (req_valid && req_write && is_size) begin
        if (region == RG_EP0) begin
          sz_ep  <= '0;
          sz_len <= LEN_W'(req_wdata[EP0_LEN_W-1:0]);
          sz_tx  <= req_wdata[EP0_DIR];
        end else begin
          sz_ep  <= ep_idx + IDX_W'(1);
          sz_len <= req_wdata[LEN_W-1:0];
          sz_tx  <= (region == RG_EPIN);
        end
      end
    end
  end

  always_comb begin
    case (region_q)
      RG_CORE, RG_FIFO: rsp_rdata = core_rdata;
      RG_EPIN:          rsp_rdata = bank_rd[0];
      RG_EPOUT:         rsp_rdata = bank_rd[1];
      RG_DEVCFG, RG_EP0, RG_SCRATCH, RG_TRST: rsp_rdata = sys_rd;
      default:          rsp_rdata = '0;
    endcase
  end

  // R2
  rsp_next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R2
  core_with_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    core_valid |-> rsp_valid);

  // R3
  fifo_fold_chk: assert property (@(posedge clk) disable iff (rst)
    (core_valid && region_q == RG_FIFO) |->
      (core_addr[1:0] == 2'b00 && core_addr >= CORE_AW'(FIFO_CORE_BASE)
       && core_addr <= CORE_AW'(FIFO_CORE_BASE) + CORE_AW'(FIFO_SEL_MASK)));

  // R12
  unmapped_alone_chk: assert property (@(posedge clk) disable iff (rst)
    unmapped |-> (rsp_valid && !core_valid && !sz_valid && rsp_rdata == '0));

  // R7
  strobe_local_chk: assert property (@(posedge clk) disable iff (rst)
    sz_valid |-> (rsp_valid && !core_valid && !unmapped));

endmodule

// File: tb/sim_regwin_decoder.sv
`timescale 1ns/1ps
module sim_regwin_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        core_valid, core_write;
  logic [1:0]  core_size;
  logic [8:0]  core_addr;
  logic [31:0] core_wdata, core_rdata;
  logic        sz_valid, sz_tx, host_mode, illegal_wr, unmapped;
  logic [3:0]  sz_ep;
  logic [30:0] sz_len;

  always #2 clk = ~clk;

  assign core_rdata = {16'hBEEF, 7'd0, core_addr};

  regwin_decoder u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .core_valid(core_valid),
    .core_write(core_write), .core_size(core_size), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_rdata(core_rdata), .sz_valid(sz_valid),
    .sz_ep(sz_ep), .sz_len(sz_len), .sz_tx(sz_tx), .host_mode(host_mode),
    .illegal_wr(illegal_wr), .unmapped(unmapped)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  int unsigned dev_m = 0, scr_m = 0, trst_m = 32'hA596, ep0_m = 0;
  int unsigned in_m[15], out_m[15];

  bit          e_rsp, e_rd, e_cv, e_cw, e_sv, e_stx, e_ill, e_unm;
  int unsigned e_rdata, e_ca, e_cwd, e_csz, e_sep, e_slen;

  task automatic chk(string tag, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "rsp_valid", rsp_valid, e_rsp);
    if (e_rsp && e_rd) chk(tag, "rsp_rdata", rsp_rdata, e_rdata);
    chk(tag, "core_valid", core_valid, e_cv);
    if (e_cv) begin
      chk(tag, "core_addr", core_addr, e_ca);
      chk(tag, "core_write", core_write, e_cw);
      chk(tag, "core_size", core_size, e_csz);
      if (e_cw) chk(tag, "core_wdata", core_wdata, e_cwd);
    end
    chk(tag, "sz_valid", sz_valid, e_sv);
    if (e_sv) begin
      chk(tag, "sz_ep", sz_ep, e_sep);
      chk(tag, "sz_len", sz_len, e_slen);
      chk(tag, "sz_tx", sz_tx, e_stx);
    end
    chk(tag, "illegal_wr", illegal_wr, e_ill);
    chk(tag, "unmapped", unmapped, e_unm);
    chk(tag, "host_mode", host_mode, (dev_m >> 16) & 1);
  endtask

  task automatic clear_exp();
    e_rsp = 0; e_rd = 0; e_cv = 0; e_cw = 0; e_sv = 0; e_stx = 0;
    e_ill = 0; e_unm = 0; e_rdata = 0; e_ca = 0; e_cwd = 0; e_csz = 0;
    e_sep = 0; e_slen = 0;
  endtask

  task automatic idle(string tag);
    req_valid = 1'b0;
    clear_exp();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic size_exp(int unsigned ep, int unsigned len, bit tx);
    e_sv = 1; e_sep = ep; e_slen = len; e_stx = tx;
  endtask

  task automatic op(string tag, bit wr, int unsigned sz, int unsigned addr, int unsigned wd);
    int unsigned off, i;
    req_valid = 1'b1; req_write = wr; req_size = 2'(sz);
    req_addr = 16'(addr); req_wdata = wd;
    clear_exp();
    e_rsp = 1; e_rd = !wr;
    off = addr & 32'hFFF;
    if (off >= 32'h400 && off < 32'h800) begin
      e_cv = 1; e_cw = wr; e_csz = sz; e_cwd = wd;
      e_ca = (off < 32'h600) ? (off & 32'h1FF) : (32'h20 + ((off >> 3) & 32'h3C));
      e_rdata = 32'hBEEF0000 | e_ca;
    end else if (off < 32'h800 || sz != 2) begin
      e_unm = 1;
    end else if (off == 32'h800) begin
      if (wr) begin
        if (wd[15]) e_ill = 1;
        else dev_m = wd;
      end
      e_rdata = dev_m;
    end else if (off == 32'h908) begin
      if (wr) begin
        ep0_m = wd & 32'h1FF;
        size_exp(0, wd & 32'h7F, wd[7]);
      end
      e_rdata = ep0_m;
    end else if (off >= 32'h90C && off < 32'h948) begin
      i = (off - 32'h90C) >> 2;
      if (wr) begin
        in_m[i] = wd;
        size_exp(i + 1, wd & 32'h7FFFFFFF, 1'b1);
      end
      e_rdata = in_m[i];
    end else if (off >= 32'h94C && off < 32'h988) begin
      i = (off - 32'h94C) >> 2;
      if (wr) begin
        out_m[i] = wd;
        size_exp(i + 1, wd & 32'h7FFFFFFF, 1'b0);
      end
      e_rdata = out_m[i];
    end else if ((off >= 32'h988 && off < 32'h9C4) || off == 32'h9C8) begin
      e_rdata = 0;
    end else if (off == 32'h9C4) begin
      if (wr) scr_m = wd;
      e_rdata = scr_m;
    end else if (off == 32'h9D8) begin
      if (wr) trst_m = wd;
      e_rdata = trst_m;
    end else begin
      e_unm = 1;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 15; i++) begin in_m[i] = 0; out_m[i] = 0; end
    repeat (3) @(negedge clk);
    clear_exp();
    compare("R13");
    rst = 1'b0;
    idle("R13");
    op("R13", 0, 2, 32'h9D8, 0);
    op("R13", 0, 2, 32'h800, 0);
    op("R13", 0, 2, 32'h918, 0);
    op("R13", 0, 2, 32'h958, 0);
    op("R13", 0, 2, 32'h908, 0);
    op("R13", 0, 2, 32'h9C4, 0);
    // core window
    op("R2", 0, 2, 32'h404, 0);
    op("R2", 1, 0, 32'h5FF, 32'h0000_00A5);
    op("R2", 0, 1, 32'h480, 0);
    op("R2", 1, 2, 32'h400, 32'hDEAD_BEEF);
    idle("R2");
    // FIFO window
    op("R3", 0, 2, 32'h600, 0);
    op("R3", 1, 0, 32'h7F8, 32'h11);
    op("R3", 1, 1, 32'h6A4, 32'h2233);
    op("R3", 0, 2, 32'h7FF, 0);
    op("R3", 0, 0, 32'h61F, 0);
    // aliasing
    op("R1", 0, 2, 32'h1404, 0);
    op("R1", 1, 2, 32'hF800, 32'h0001_0003);
    op("R1", 0, 2, 32'h0800, 0);
    // config and host mode
    op("R5", 1, 2, 32'h800, 32'h0000_0042);
    op("R5", 0, 2, 32'h800, 0);
    op("R5", 1, 2, 32'h800, 32'h0001_0003);
    op("R5", 0, 2, 32'h800, 0);
    // product test mode rejected
    op("R6", 1, 2, 32'h800, 32'h0000_8000);
    op("R6", 0, 2, 32'h800, 0);
    op("R6", 1, 2, 32'h800, 32'hFFFF_FFFF);
    idle("R6");
    op("R6", 0, 2, 32'h800, 0);
    // endpoint zero
    op("R7", 1, 2, 32'h908, 32'hFFFF_FF85);
    op("R7", 0, 2, 32'h908, 0);
    op("R7", 1, 2, 32'h908, 32'h0000_007F);
    op("R7", 0, 2, 32'h908, 0);
    // transmit bank
    for (int i = 0; i < 15; i++) op("R8", 1, 2, 32'h90C + 4 * i, 32'h8000_1000 + i * 32'h111);
    for (int i = 0; i < 15; i++) op("R8", 0, 2, 32'h90C + 4 * i, 0);
    // receive bank
    for (int i = 0; i < 15; i++) op("R9", 1, 2, 32'h94C + 4 * i, 32'h0070_0000 + i);
    for (int i = 0; i < 15; i++) op("R9", 0, 2, 32'h94C + 4 * i, 0);
    op("R9", 0, 2, 32'h90C, 0);
    op("R9", 0, 2, 32'h944, 0);
    // scratch and test reset
    op("R10", 1, 2, 32'h9C4, 32'h1234_5678);
    op("R10", 0, 2, 32'h9C4, 0);
    op("R10", 1, 2, 32'h9D8, 32'h0000_0001);
    op("R10", 0, 2, 32'h9D8, 0);
    // zero-read locations
    op("R11", 1, 2, 32'h988, 32'hFFFF_FFFF);
    op("R11", 0, 2, 32'h988, 0);
    op("R11", 1, 2, 32'h9C0, 32'h5555_5555);
    op("R11", 0, 2, 32'h9C0, 0);
    op("R11", 1, 2, 32'h9C8, 32'hAAAA_AAAA);
    op("R11", 0, 2, 32'h9C8, 0);
    op("R11", 0, 2, 32'h984, 0);
    op("R11", 0, 2, 32'h9C4, 0);
    // narrow accesses to system window
    op("R4", 0, 1, 32'h800, 0);
    op("R4", 1, 0, 32'h9C4, 32'hFF);
    op("R4", 1, 1, 32'h90C, 32'h7777);
    op("R4", 0, 2, 32'h9C4, 0);
    op("R4", 0, 2, 32'h90C, 0);
    // unmapped
    op("R12", 0, 2, 32'h000, 0);
    op("R12", 1, 2, 32'h804, 32'hFFFF_FFFF);
    op("R12", 0, 2, 32'hA00, 0);
    op("R12", 1, 2, 32'h3FC, 32'h1);
    op("R12", 0, 2, 32'h90A, 0);
    idle("R12");
    op("R12", 0, 2, 32'h800, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule